// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller with a small datapath. Three code registers hold the secret combination, one 4-bit digit each. Each register is written from the shared digit bus when its load strobe is high.

A user presents the combination one digit at a time on the same bus. Each digit is offered with a valid pulse. The controller chooses which stored digit is compared next, and an equality comparator reports whether the presented digit matches it. Three matches in order open the lock. One mismatch locks the block into an error state. The open state and the error state are both left only through reset.

The state is held in a register whose bits are the outputs. The low three bits are a one-hot select that names the digit awaited next. The top bit is the open indication. No output decoding sits after the state flops.

Digit entry uses a valid/ready pair. The block accepts a digit on a clock edge where `entry_valid` and `entry_ready` are both high. `entry_ready` is high while a digit is awaited, and low in the open and error states. A digit offered while ready is low is dropped, not held back, because the lock never becomes ready again without reset. A source should therefore treat low ready as "entry closed" rather than as temporary back-pressure. Each accepted pulse is evaluated exactly once.

Top module: `combo_lock`

## Requirements
- R1: A high `rst` at a clock edge puts the lock in the first-digit state: `sel_out`=001, `unlocked`=0, `entry_ready`=1 after that edge, whatever the prior state.
- R2: At a clock edge, code register k (k=0,1,2) takes `dig_in` when `load_en[k]` is 1. Several registers may load the same value in one cycle. A register whose bit is 0 keeps its value. Registers keep their contents through `rst`.
- R3: `sel_out` is 001, 010 or 100 while digit 1, 2 or 3 is awaited, and 000 in the open and error states. `unlocked` is 1 only in the open state.
- R4: An accepted digit that matches the awaited code register moves the lock to the next digit. A match on the third digit opens the lock.
- R5: An accepted digit that does not match sends the lock to the error state (`sel_out`=000, `unlocked`=0, `entry_ready`=0).
- R6: With no accepted digit and no reset, the state holds.
- R7: `entry_ready` is 0 in the open and error states. A valid pulse there changes nothing, and only `rst` leaves those states.
- R8: While `entry_ready` is 1, `match` is 1 exactly when `dig_in` equals the code register selected by `sel_out`.
- R9: When a digit is accepted in the same cycle that its code register loads, the comparison uses the register's contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous lock reset, active high |
| dig_in | input | 4 | Digit bus, used both for loading codes and for entry |
| load_en | input | 3 | Per-register code load strobes, bit k for digit k+1 |
| entry_valid | input | 1 | A digit is offered on `dig_in` |
| entry_ready | output | 1 | The lock accepts a digit |
| match | output | 1 | `dig_in` equals the selected code digit |
| sel_out | output | 3 | One-hot select of the awaited code digit |
| unlocked | output | 1 | Lock is open |

## Verification
The bench offers valid pulses in the open and error states. A design that kept its ready high, or that let the pulse through, would change state. The bench loads a register in the same cycle as a digit is entered to that register. A design that compared against the new value would take the wrong branch. Multi-bit load strobes and reset between attempts show whether a register is skipped or cleared by reset. A mismatch on the last digit, and gaps without valid between digits, show whether the design skips a digit or re-evaluates a held value.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned LOCK_DIGIT_W  = 4;
  localparam int unsigned LOCK_N_DIGITS = 3;
endpackage

// File: rtl/code_bank.sv
module code_bank #(
  parameter int unsigned W = lock_pkg::LOCK_DIGIT_W,
  parameter int unsigned N = lock_pkg::LOCK_N_DIGITS
) (
  input  logic               clk,
  input  logic [W-1:0]       wr_data,
  input  logic [N-1:0]       wr_en,
  output logic [N-1:0][W-1:0] codes
);
  // Each register loads independently; reset deliberately not applied.
  for (genvar k = 0; k < N; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wr_en[k]) codes[k] <= wr_data;
    end
  end
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int unsigned W = lock_pkg::LOCK_DIGIT_W,
  parameter int unsigned N = lock_pkg::LOCK_N_DIGITS
) (
  input  logic [N-1:0][W-1:0] codes,
  input  logic [N-1:0]        sel,
  input  logic [W-1:0]        probe,
  output logic                eq
);
  logic [W-1:0] picked;

  // AND-OR mux over a one-hot select; all-zero select yields zero.
  always_comb begin
    picked = '0;
    for (int k = 0; k < N; k++) begin
      if (sel[k]) picked = picked | codes[k];
    end
  end

  assign eq = (picked == probe);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int unsigned N = lock_pkg::LOCK_N_DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         eq,
  output logic [N:0]   state
);
  localparam logic [N:0] ST_FIRST = (N+1)'(1);
  localparam logic [N:0] ST_ERR   = '0;

  logic [N:0] state_nx;

  always_comb begin
    state_nx = state;
    if (take) begin
      if (eq) state_nx = state << 1;
      else    state_nx = ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FIRST;
    else     state <= state_nx;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int unsigned DIGIT_W  = lock_pkg::LOCK_DIGIT_W,
  parameter int unsigned N_DIGITS = lock_pkg::LOCK_N_DIGITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIGIT_W-1:0]  dig_in,
  input  logic [N_DIGITS-1:0] load_en,
  input  logic                entry_valid,
  output logic                entry_ready,
  output logic                match,
  output logic [N_DIGITS-1:0] sel_out,
  output logic                unlocked
);
  logic [N_DIGITS-1:0][DIGIT_W-1:0] codes;
  logic [N_DIGITS:0]                state;
  logic                             take;

  code_bank #(.W(DIGIT_W), .N(N_DIGITS)) u_bank (
    .clk(clk), .wr_data(dig_in), .wr_en(load_en), .codes(codes)
  );

  digit_select #(.W(DIGIT_W), .N(N_DIGITS)) u_sel (
    .codes(codes), .sel(sel_out), .probe(dig_in), .eq(match)
  );

  lock_ctrl #(.N(N_DIGITS)) u_ctrl (
    .clk(clk), .rst(rst), .take(take), .eq(match), .state(state)
  );

  assign sel_out     = state[N_DIGITS-1:0];
  assign unlocked    = state[N_DIGITS];
  assign entry_ready = |sel_out;
  assign take        = entry_valid & entry_ready;
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
  parameter int unsigned N = lock_pkg::LOCK_N_DIGITS
) (
  input logic         clk,
  input logic         rst,
  input logic         entry_valid,
  input logic         entry_ready,
  input logic         match,
  input logic [N-1:0] sel_out,
  input logic         unlocked
);
  // R1
  reset_first_chk: assert property (@(posedge clk)
    rst |=> (sel_out == N'(1)) && !unlocked);

  // R3
  onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({unlocked, sel_out}));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && entry_ready && match) |=>
      ({unlocked, sel_out} == ($past({unlocked, sel_out}) << 1)));

  // R5
  mismatch_err_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && entry_ready && !match) |=>
      (sel_out == '0) && !unlocked && !entry_ready);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(entry_valid && entry_ready) |=> $stable(sel_out) && $stable(unlocked));

  // R7
  closed_stays_chk: assert property (@(posedge clk) disable iff (rst)
    !entry_ready |=> !entry_ready);
endmodule

bind combo_lock lock_chk #(.N(N_DIGITS)) u_chk (
  .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_ready(entry_ready),
  .match(match), .sel_out(sel_out), .unlocked(unlocked)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dig_in = '0;
  logic [2:0] load_en = '0;
  logic       entry_valid = 1'b0;
  logic       entry_ready, match, unlocked;
  logic [2:0] sel_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model: pos 0..2 awaiting digit, 3 open, 4 error
  int m_pos = 0;
  int m_code [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock u0 (
    .clk(clk), .rst(rst), .dig_in(dig_in), .load_en(load_en),
    .entry_valid(entry_valid), .entry_ready(entry_ready), .match(match),
    .sel_out(sel_out), .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_sel();
    return (m_pos < 3) ? (1 << m_pos) : 0;
  endfunction

  // Drive one cycle of inputs at the falling edge, step model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input bit r, input bit v, input int d, input int ld, input string tag);
    bit rdy;
    bit exp_m;
    rst = r; entry_valid = v; dig_in = 4'(d); load_en = 3'(ld);
    #1;
    rdy = (m_pos < 3);
    if (rdy) begin
      exp_m = (d == m_code[m_pos]);
      // R8 comparator against selected digit
      check(match == exp_m, {tag, " R8 match"}, int'(match), int'(exp_m));
    end
    @(posedge clk);
    if (r) m_pos = 0;
    else if (v && rdy) m_pos = (d == m_code[m_pos]) ? m_pos + 1 : 4;
    for (int k = 0; k < 3; k++) if (ld[k]) m_code[k] = d; // R2, after compare (R9)
    @(negedge clk);
    check(int'(sel_out) == exp_sel(), {tag, " R3 sel"}, int'(sel_out), exp_sel());
    check(unlocked == (m_pos == 3), {tag, " R3 unlocked"}, int'(unlocked), int'(m_pos == 3));
    check(entry_ready == (m_pos < 3), {tag, " R7 ready"}, int'(entry_ready), int'(m_pos < 3));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 9, 0, tag);
  endtask

  task automatic enter3(input int a, input int b, input int c, input string tag);
    step(0, 1, a, 0, tag);
    step(0, 1, b, 0, tag);
    step(0, 1, c, 0, tag);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, "R1 reset");
    check(int'(sel_out) == 1, "R1 first digit", int'(sel_out), 1);

    // R2: separate loads while awaiting, no valid
    step(0, 0, 3, 3'b001, "R2 load1");
    step(0, 0, 4, 3'b010, "R2 load2");
    step(0, 0, 2, 3'b100, "R2 load3");

    // R4, R6: correct sequence with gaps, opens
    step(0, 1, 3, 0, "R4 d1");
    idle(2, "R6 gap");
    step(0, 1, 4, 0, "R4 d2");
    idle(1, "R6 gap");
    step(0, 1, 2, 0, "R4 d3 open");
    check(unlocked == 1'b1, "R4 opened", int'(unlocked), 1);

    // R7: valid in open is ignored
    step(0, 1, 3, 0, "R7 open ignore");
    step(0, 1, 9, 0, "R7 open ignore");
    idle(2, "R7 open hold");
    check(unlocked == 1'b1, "R7 still open", int'(unlocked), 1);

    // R5: wrong second digit
    step(1, 0, 0, 0, "R1 reset from open");
    step(0, 1, 3, 0, "R5 d1");
    step(0, 1, 5, 0, "R5 wrong d2");
    check(int'(sel_out) == 0 && !entry_ready, "R5 err", int'(sel_out), 0);
    step(0, 1, 4, 0, "R7 err ignore");
    step(0, 1, 2, 0, "R7 err ignore");

    // R2: codes survive reset; wrong last digit
    step(1, 0, 0, 0, "R1 reset from err");
    enter3(3, 4, 2, "R2 retained");
    check(unlocked == 1'b1, "R2 retained opens", int'(unlocked), 1);
    step(1, 0, 0, 0, "R1 reset");
    enter3(3, 4, 3, "R5 wrong d3");

    // R2: multi-load, boundary value 15
    step(1, 0, 0, 0, "R1 reset");
    step(0, 0, 15, 3'b111, "R2 multi load");
    enter3(15, 15, 15, "R2 all fifteen");
    check(unlocked == 1'b1, "R2 multi opens", int'(unlocked), 1);

    // R9: load and entry in same cycle compares old contents
    step(1, 0, 0, 0, "R1 reset");
    step(0, 1, 5, 3'b001, "R9 same-cycle mismatch");
    check(int'(sel_out) == 0, "R9 old code used", int'(sel_out), 0);
    step(1, 0, 0, 0, "R1 reset");
    step(0, 1, 5, 3'b010, "R9 d1 with load2"); // d1 code still 5 now; loads 5 into reg2
    step(0, 1, 5, 0, "R9 d2 new code");
    step(0, 1, 0, 3'b100, "R9 d3 old code");
    check(int'(sel_out) == 0 && !unlocked, "R9 d3 vs old 15", int'(sel_out), 0);

    // R4: reset mid-sequence restarts
    step(1, 0, 0, 0, "R1 reset");
    step(0, 1, 5, 0, "R4 d1");
    step(1, 1, 5, 0, "R1 reset wins");
    enter3(5, 5, 0, "R4 after restart");
    check(unlocked == 1'b1, "R4 reopen", int'(unlocked), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule